// File: doc/BRIEF.md
# Byte-Synchronous Character Receiver

This block turns a character-synchronous serial stream into framed characters. When enabled, it slides a window over the incoming bits until it sees the programmed SYNC pattern. It then locks its character framing. If the character that follows is also SYNC, the data path opens. A second character that is not SYNC sends the block back to searching. From then on, each character is collected least-significant bit first and handed out on a valid/ready output. Character width is programmable from 5 to 8 bits. SYNC fill inside a message can be dropped or passed through.

Vertical redundancy checking is optional. When it is on, one parity bit follows the data bits of every character. The block recomputes the parity, flags a mismatch on the character and pulses a status strobe. The parity bit itself is never delivered. Block-check (CRC) computation is left to software or to a neighbouring block.

Back-pressure rules: a character is held on `out_data` with `out_valid` high until `out_ready` is seen high at a clock edge. The serial side cannot be stalled. If a new character completes while the held one is still unread, the new one replaces it and carries an overrun flag. If the consumer takes the old character in the same edge, no overrun is flagged.

Top module: `sync_rx`

## Requirements
- R1: The data path opens only after two back-to-back characters each equal to the low N bits of `sync_char`. A match followed by any other character returns the block to bit-by-bit searching, and nothing is delivered.
- R2: With `strip_sync`=1, SYNC characters after the opening pair are discarded, whether they come before or inside the message. The first non-SYNC character is delivered, and `rx_active` rises in the same cycle as its `out_valid`.
- R3: With `strip_sync`=0, the first character after the opening pair is delivered even if it is SYNC, and later SYNC characters are delivered as data.
- R4: N = 5 + `char_len` (0..3 gives 5..8 bits). Bits arrive least-significant first on cycles with `rx_bit_vld`=1. Delivered data is right-aligned with the upper bits zero.
- R5: With `par_en`=1, one parity bit follows the N data bits. It is correct when the total number of ones is odd (`par_odd`=1) or even (`par_odd`=0). A mismatch sets `out_perr` on that character, and the parity bit never appears in `out_data`.
- R6: `perr_stb` is a one-cycle pulse in the first cycle that an errored character is presented, and it fires for no other character.
- R7: While `out_valid`=1 and `out_ready`=0 and no new character completes, `out_valid` stays high and `out_data` stays stable. A handshake with no new character clears `out_valid`.
- R8: A character completing while the held one is unread replaces it and sets `out_ovr`=1. If `out_ready` is high in that same edge, the old character is taken and the new one has `out_ovr`=0.
- R9: `rx_en`=0 clears all receiver state at the next edge: `out_valid`=0, `rx_active`=0, and searching restarts.
- R10: After reset, `out_valid`, `perr_stb` and `rx_active` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; low clears all state |
| rx_bit_vld | input | 1 | Serial bit present this cycle |
| rx_bit | input | 1 | Serial data bit |
| sync_char | input | 8 | SYNC pattern (low N bits used) |
| char_len | input | 2 | Data width code, N = 5 + value |
| strip_sync | input | 1 | Discard SYNC characters after the opening pair |
| par_en | input | 1 | Parity bit present and checked |
| par_odd | input | 1 | 1 = odd parity, 0 = even |
| out_valid | output | 1 | Character held for the consumer |
| out_ready | input | 1 | Consumer takes the character |
| out_data | output | 8 | Received character, right-aligned |
| out_perr | output | 1 | Parity mismatch on this character |
| out_ovr | output | 1 | Previous character was lost |
| perr_stb | output | 1 | One-cycle parity error strobe |
| rx_active | output | 1 | Data path open |

## Verification
Completion of a new character and the consumer's handshake on the held one can fall in the same clock edge. The bench holds `out_ready` low while one character waits. It then raises `out_ready` in exactly the cycle that carries the last bit of the next character. The scoreboard must receive both characters in order, and the second must have `out_ovr`=0. A contrasting run that keeps `out_ready` low through that edge must deliver only the newer character with `out_ovr`=1.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  typedef enum logic [2:0] {
    ST_HUNT   = 3'd0,
    ST_PTAIL  = 3'd1,
    ST_SYNC2  = 3'd2,
    ST_ARM    = 3'd3,
    ST_ACTIVE = 3'd4
  } rx_state_t;
endpackage

// File: rtl/sync_rx_deser.sv
module sync_rx_deser #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              bit_vld,
  input  logic              bit_in,
  input  logic [CNT_W-1:0]  nlen,
  input  logic [DATA_W-1:0] mask,
  input  logic [DATA_W-1:0] sync_m,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              locked,
  output logic              hit,
  output logic              frame_done,
  output logic [DATA_W-1:0] frame_data,
  output logic              frame_perr
);
  logic [DATA_W-1:0] shreg, win_next;
  logic [CNT_W-1:0]  cnt, cnt_inc;
  logic              at_par;

  assign cnt_inc  = cnt + CNT_W'(1);
  assign at_par   = (cnt == nlen);
  assign win_next = ({1'b0, shreg[DATA_W-1:1]} | (DATA_W'(bit_in) << (nlen - CNT_W'(1)))) & mask;

  assign hit        = !locked && bit_vld && (cnt_inc >= nlen) && (win_next == sync_m);
  assign frame_done = locked && bit_vld && (at_par || (!par_en && cnt_inc == nlen));
  assign frame_data = at_par ? shreg : win_next;
  assign frame_perr = par_en && at_par && ((^shreg ^ bit_in) != par_odd);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (clr) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (bit_vld) begin
      if (!locked) begin
        shreg <= win_next;
        if (hit)              cnt <= par_en ? nlen : '0;
        else if (cnt < nlen)  cnt <= cnt_inc;
      end else if (!at_par) begin
        shreg <= win_next;
        cnt   <= (!par_en && cnt_inc == nlen) ? '0 : cnt_inc;
      end else begin
        cnt <= '0;
      end
    end
  end

  // R4
  frame_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> ((frame_data & ~mask) == '0));
endmodule

// File: rtl/sync_rx_ctrl.sv
module sync_rx_ctrl
  import sync_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              hit,
  input  logic              frame_done,
  input  logic [DATA_W-1:0] frame_data,
  input  logic [DATA_W-1:0] sync_m,
  input  logic              strip,
  input  logic              par_en,
  output logic              locked,
  output logic              load,
  output logic              rx_active
);
  rx_state_t st, st_nx;
  logic      is_sync, keep;

  assign is_sync   = (frame_data == sync_m);
  assign keep      = !(strip && is_sync);
  assign locked    = (st != ST_HUNT);
  assign rx_active = (st == ST_ACTIVE);
  assign load      = frame_done && keep && (st == ST_ARM || st == ST_ACTIVE);

  always_comb begin
    st_nx = st;
    case (st)
      ST_HUNT:   if (hit) st_nx = par_en ? ST_PTAIL : ST_SYNC2;
      ST_PTAIL:  if (frame_done) st_nx = ST_SYNC2;
      ST_SYNC2:  if (frame_done) st_nx = is_sync ? ST_ARM : ST_HUNT;
      ST_ARM:    if (frame_done && keep) st_nx = ST_ACTIVE;
      ST_ACTIVE: st_nx = ST_ACTIVE;
      default:   st_nx = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   st <= ST_HUNT;
    else if (clr) st <= ST_HUNT;
    else          st <= st_nx;
  end

  // R2
  active_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_active) |-> $past(load));

  // R1
  no_load_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> locked);
endmodule

// File: rtl/sync_rx_outreg.sv
module sync_rx_outreg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              load,
  input  logic [DATA_W-1:0] d_data,
  input  logic              d_perr,
  input  logic              ready,
  output logic              valid,
  output logic [DATA_W-1:0] data,
  output logic              perr,
  output logic              ovr,
  output logic              perr_stb
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0; data <= '0; perr <= 1'b0; ovr <= 1'b0; perr_stb <= 1'b0;
    end else if (clr) begin
      valid <= 1'b0; data <= '0; perr <= 1'b0; ovr <= 1'b0; perr_stb <= 1'b0;
    end else begin
      perr_stb <= load && d_perr;
      if (load) begin
        valid <= 1'b1;
        data  <= d_data;
        perr  <= d_perr;
        ovr   <= valid && !ready;
      end else if (valid && ready) begin
        valid <= 1'b0;
      end
    end
  end

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && !load && !clr) |=> (valid && $stable(data)));

  // R8
  ovr_on_collision_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && load && !clr) |=> ovr);
endmodule

// File: rtl/sync_rx.sv
module sync_rx #(
  parameter int DATA_W  = 8,
  parameter int LEN_W   = 2,
  parameter int MIN_LEN = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              rx_bit_vld,
  input  logic              rx_bit,
  input  logic [DATA_W-1:0] sync_char,
  input  logic [LEN_W-1:0]  char_len,
  input  logic              strip_sync,
  input  logic              par_en,
  input  logic              par_odd,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_perr,
  output logic              out_ovr,
  output logic              perr_stb,
  output logic              rx_active
);
  localparam int CNT_W = $clog2(DATA_W + 2);

  logic [CNT_W-1:0]  nlen;
  logic [DATA_W-1:0] mask, sync_m, f_data;
  logic              clr, hit, f_done, f_perr, locked, load;

  assign clr    = !rx_en;
  assign nlen   = CNT_W'(MIN_LEN) + CNT_W'(char_len);
  assign mask   = (DATA_W'(1) << nlen) - DATA_W'(1);
  assign sync_m = sync_char & mask;

  sync_rx_deser #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_deser (
    .clk(clk), .rst_n(rst_n), .clr(clr), .bit_vld(rx_bit_vld), .bit_in(rx_bit),
    .nlen(nlen), .mask(mask), .sync_m(sync_m), .par_en(par_en), .par_odd(par_odd),
    .locked(locked), .hit(hit), .frame_done(f_done), .frame_data(f_data),
    .frame_perr(f_perr)
  );

  sync_rx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clr(clr), .hit(hit), .frame_done(f_done),
    .frame_data(f_data), .sync_m(sync_m), .strip(strip_sync), .par_en(par_en),
    .locked(locked), .load(load), .rx_active(rx_active)
  );

  sync_rx_outreg #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load(load), .d_data(f_data),
    .d_perr(f_perr), .ready(out_ready), .valid(out_valid), .data(out_data),
    .perr(out_perr), .ovr(out_ovr), .perr_stb(perr_stb)
  );

  // R6
  perr_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    perr_stb |-> (out_valid && out_perr && !$past(perr_stb)));

  // R9
  en_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!out_valid && !rx_active));
endmodule

// File: tb/sync_rx_bench.sv
module sync_rx_bench;
  logic       clk = 1'b0, rst_n = 1'b0, rx_en = 1'b0, rx_bit_vld = 1'b0, rx_bit = 1'b0;
  logic [7:0] sync_char = 8'h16;
  logic [1:0] char_len = 2'd3;
  logic       strip_sync = 1'b1, par_en = 1'b0, par_odd = 1'b0, out_ready = 1'b1;
  logic       out_valid, out_perr, out_ovr, perr_stb, rx_active;
  logic [7:0] out_data;

  int checks = 0, failures = 0, stb_count = 0, nbits = 8;
  logic [9:0] expq[$];

  always #10 clk = ~clk;

  sync_rx u_sync_rx (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_bit_vld(rx_bit_vld), .rx_bit(rx_bit),
    .sync_char(sync_char), .char_len(char_len), .strip_sync(strip_sync),
    .par_en(par_en), .par_odd(par_odd), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_perr(out_perr), .out_ovr(out_ovr),
    .perr_stb(perr_stb), .rx_active(rx_active)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic send_bit(input logic b, input bit rdy_now);
    tick(); rx_bit_vld = 1'b1; rx_bit = b;
    if (rdy_now) out_ready = 1'b1;
    tick(); rx_bit_vld = 1'b0;
  endtask

  task automatic send_char(input logic [7:0] c, input bit bad_par, input bit rdy_last);
    logic p;
    p = (^(c & ((8'd1 << nbits) - 8'd1))) ^ par_odd ^ bad_par;
    for (int i = 0; i < nbits; i++)
      send_bit(c[i], rdy_last && !par_en && i == nbits - 1);
    if (par_en) send_bit(p, rdy_last);
  endtask

  task automatic expect_chr(input logic [7:0] d, input bit pe, input bit ov);
    expq.push_back({d, pe, ov});
  endtask

  task automatic drain(input string req);
    repeat (6) tick();
    check(expq.size() == 0, req, expq.size(), 0);
  endtask

  task automatic restart(input int len_code);
    rx_en = 1'b0; tick();
    char_len = 2'(len_code); nbits = 5 + len_code;
    rx_en = 1'b1; tick();
  endtask

  // scoreboard monitor: pops on every handshake, away from the clock edge
  always @(negedge clk) begin
    if (perr_stb) stb_count++;
    if (rst_n && out_valid && out_ready) begin
      if (expq.size() == 0) begin
        check(0, "R1/R2 unexpected char", out_data, 0);
      end else begin
        logic [9:0] e;
        e = expq.pop_front();
        check({out_data, out_perr, out_ovr} == e, "R3/R4/R5/R8 char", {out_data, out_perr, out_ovr}, e);
        check(rx_active, "R2 active with data", rx_active, 1);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) tick();
    check(!out_valid && !rx_active && !perr_stb, "R10 reset", {out_valid, rx_active, perr_stb}, 0);
    rst_n = 1'b1; tick();

    // Test A: 8 bits, strip, no parity
    restart(3);
    repeat (3) send_bit(1'b1, 1'b0);
    send_char(8'h16, 0, 0); send_char(8'h41, 0, 0);      // single SYNC: R1 back to hunt
    repeat (4) tick();
    check(!rx_active, "R1 single sync", rx_active, 0);
    send_char(8'h16, 0, 0); send_char(8'h16, 0, 0);
    send_char(8'h16, 0, 0);                                // stripped before message: R2
    check(!rx_active, "R2 sync before msg", rx_active, 0);
    expect_chr(8'hA5, 0, 0); send_char(8'hA5, 0, 0);
    expect_chr(8'h3C, 0, 0); send_char(8'h3C, 0, 0);
    send_char(8'h16, 0, 0);                                // stripped mid-message: R2
    expect_chr(8'h81, 0, 0); send_char(8'h81, 0, 0);
    drain("R2 strip drain");
    // R7 hold while not ready, then R9 clear
    out_ready = 1'b0;
    send_char(8'h77, 0, 0);
    repeat (5) tick();
    check(out_valid && out_data == 8'h77, "R7 hold", out_data, 8'h77);
    rx_en = 1'b0; tick(); tick();
    check(!out_valid && !rx_active, "R9 disable clears", {out_valid, rx_active}, 0);
    out_ready = 1'b1;

    // Test B: 5 bits, no strip, odd parity
    strip_sync = 1'b0; par_en = 1'b1; par_odd = 1'b1;
    restart(0);
    repeat (2) send_bit(1'b1, 1'b0);
    send_char(8'h16, 0, 0); send_char(8'h16, 0, 0);
    expect_chr(8'h16, 0, 0); send_char(8'h16, 0, 0);       // R3 first char is SYNC
    expect_chr(8'h0B, 0, 0); send_char(8'h0B, 0, 0);
    expect_chr(8'h1F, 1, 0); send_char(8'h1F, 1, 0);       // R5 bad parity
    expect_chr(8'h16, 0, 0); send_char(8'h16, 0, 0);       // R3 SYNC passed mid-message
    expect_chr(8'h05, 0, 0); send_char(8'h05, 0, 0);       // R4 upper bits zero
    drain("R3 pass drain");
    check(stb_count == 1, "R6 strobe count", stb_count, 1);

    // Test C: 6 bits, strip, even parity, overrun and coincidence
    strip_sync = 1'b1; par_odd = 1'b0;
    restart(1);
    send_bit(1'b1, 1'b0);
    send_char(8'h16, 0, 0); send_char(8'h16, 0, 0);
    expect_chr(8'h2A, 0, 0); send_char(8'h2A, 0, 0);
    drain("R5 even parity");
    out_ready = 1'b0;
    send_char(8'h11, 0, 0);
    expect_chr(8'h22, 0, 1); send_char(8'h22, 0, 0);       // R8 overrun replaces
    tick(); out_ready = 1'b1;
    drain("R8 overrun");
    out_ready = 1'b0;
    expect_chr(8'h15, 0, 0); send_char(8'h15, 0, 0);
    expect_chr(8'h0C, 0, 0); send_char(8'h0C, 0, 1);       // R8 taken in same edge
    drain("R8 coincidence");
    check(stb_count == 1, "R6 no extra strobe", stb_count, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule